// File: doc/BRIEF.md
# Coprocessor Conditional Branch Sequencer

This block runs the main-processor side of a branch whose condition is judged by a separate coprocessor. After a start pulse it reads the instruction stream one 16-bit word at a time through a simple fetch port and checks the operation word's format. It then writes a 6-bit condition selector to the coprocessor's condition register. Next it polls the coprocessor's response register until a final true/false answer comes back. Service requests get a one-cycle strobe. Busy answers only cause another read.

Once the answer is in, the sequencer reads and discards the optional coprocessor-defined words. It then fetches a 16-bit or 32-bit displacement and adds it to the address of the first word after the operation word. The result is reported with a single-cycle done pulse, a taken flag, the target address and two error flags: illegal format and poll timeout.

Top module: `cpb_branch_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fetch_req`, `cp_wr`, `cp_rd` and `cp_svc` are low. A `start` pulse while `busy` is high has no effect on the running instruction or on its results.
- R2: An operation word is accepted only when bits [15:12] equal 1111 and bits [8:6] equal 010 (word form) or 011 (long form). Any other word sets `illegal`, completes with `done`, leaves `taken` low and `target` zero, and makes no coprocessor access.
- R3: Bits [11:9] of the operation word appear on `cp_sel` during every coprocessor write and read of that instruction.
- R4: Exactly one write happens before any read. It goes to the condition register (`cp_reg` = 0) with `cp_wdata` = {10'b0, op[5:0]}. All reads use `cp_reg` = 1.
- R5: A response with bits [15:13] = 000 is final, and its bit 0 is the condition result. A response with bit 15 = 1 means busy, and polling continues on the next cycle.
- R6: Any other response code is a service request. It causes exactly one `cp_svc` pulse in the cycle after that read, with no read in that cycle, and polling resumes afterwards.
- R7: `ext_count` is latched at start. After the final answer, that many words are fetched and discarded.
- R8: In the word form, the displacement word is sign-extended and `target` = `instr_addr` + 2 + displacement.
- R9: In the long form, a high word and then a low word are fetched, and `target` = `instr_addr` + 2 + {high, low}.
- R10: If `POLL_LIMIT` (256) reads return no final answer, the block sets `proto_err`, completes with `taken` low and `target` zero, and no displacement is fetched. A final answer on read number `POLL_LIMIT` still succeeds.
- R11: `done` lasts exactly one cycle. `taken`, `target`, `illegal` and `proto_err` hold their values until the next accepted start. `taken` is set only on a successful final answer whose result bit is 1.
- R12: Fetch addresses start at `instr_addr` and rise by 2 for each accepted word. A word is accepted only in a cycle where both `fetch_req` and `fetch_valid` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (used only when idle) |
| instr_addr | input | ADDR_W | Address of the operation word |
| ext_count | input | EXT_W | Number of coprocessor-defined words to skip |
| fetch_req | output | 1 | Word fetch request |
| fetch_addr | output | ADDR_W | Address of the requested word |
| fetch_valid | input | 1 | Requested word is present this cycle |
| fetch_data | input | 16 | Fetched word |
| cp_sel | output | 3 | Coprocessor identifier |
| cp_reg | output | 1 | Register select: 0 condition, 1 response |
| cp_wr | output | 1 | Register write strobe |
| cp_rd | output | 1 | Register read strobe; `cp_rdata` sampled in the same cycle |
| cp_wdata | output | 16 | Write data |
| cp_rdata | input | 16 | Read data from the response register |
| cp_svc | output | 1 | One-cycle acknowledge of a service request |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch taken |
| target | output | ADDR_W | Branch target address |
| illegal | output | 1 | Illegal operation-word format |
| proto_err | output | 1 | Poll limit reached without a final answer |

## Verification
A wrong state or a corrupt poll counter shows up at the ports within a few cycles. It appears as a missing or duplicated `cp_svc` pulse, a read during an acknowledge cycle, or a read count that differs from the number of responses handed out before the final one. A bad program-counter or extension count shows as a fetch address that breaks the +2 sequence, or as a wrong number of fetched words. Both are visible on the first wrong word. A wrong displacement path is only visible at `target` in the `done` cycle, so every run compares that value against an independent sum.

// File: rtl/cpb_pkg.sv
package cpb_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DECODE,
        S_WRITE_COND,
        S_POLL,
        S_SKIP_EXT,
        S_FETCH_DISP_HI,
        S_FETCH_DISP_LO,
        S_DONE
    } cpb_state_e;

    typedef enum logic [1:0] {
        RSP_NULL,
        RSP_BUSY,
        RSP_SERVICE
    } cpb_resp_e;

    localparam logic [3:0] OP_FLINE   = 4'b1111;
    localparam logic [2:0] FMT_WORD   = 3'b010;
    localparam logic [2:0] FMT_LONG   = 3'b011;
    localparam logic       CP_REG_CND = 1'b0;
    localparam logic       CP_REG_RSP = 1'b1;

endpackage

// File: rtl/cpb_opdec.sv
module cpb_opdec
    import cpb_pkg::*;
(
    input  logic [15:0] op_word,
    output logic        legal,
    output logic        is_long,
    output logic [2:0]  cpid,
    output logic [5:0]  cond_sel
);
    logic [2:0] fmt;

    always_comb begin
        fmt      = op_word[8:6];
        legal    = (op_word[15:12] == OP_FLINE) &&
                   ((fmt == FMT_WORD) || (fmt == FMT_LONG));
        is_long  = (fmt == FMT_LONG);
        cpid     = op_word[11:9];
        cond_sel = op_word[5:0];
    end
endmodule

// File: rtl/cpb_resp_class.sv
module cpb_resp_class
    import cpb_pkg::*;
(
    input  logic [15:0] rsp_word,
    output cpb_resp_e   rsp_kind,
    output logic        cond_bit
);
    always_comb begin
        cond_bit = rsp_word[0];
        if (rsp_word[15:13] == 3'b000) begin
            rsp_kind = RSP_NULL;
        end else if (rsp_word[15]) begin
            rsp_kind = RSP_BUSY;
        end else begin
            rsp_kind = RSP_SERVICE;
        end
    end
endmodule

// File: rtl/cpb_target.sv
module cpb_target #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              is_long,
    input  logic [15:0]       hi_word,
    input  logic [15:0]       lo_word,
    output logic [ADDR_W-1:0] tgt_addr
);
    logic [31:0]       disp32;
    logic [ADDR_W-1:0] disp_ext;

    always_comb begin
        disp32 = is_long ? {hi_word, lo_word} : {{16{lo_word[15]}}, lo_word};
    end

    generate
        if (ADDR_W > 32) begin : g_wide
            always_comb disp_ext = {{(ADDR_W-32){disp32[31]}}, disp32};
        end else if (ADDR_W == 32) begin : g_exact
            always_comb disp_ext = disp32;
        end else begin : g_narrow
            always_comb disp_ext = disp32[ADDR_W-1:0];
        end
    endgenerate

    always_comb tgt_addr = base_addr + disp_ext;
endmodule

// File: rtl/cpb_branch_seq.sv
module cpb_branch_seq
    import cpb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int POLL_LIMIT = 256,
    parameter int EXT_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] instr_addr,
    input  logic [EXT_W-1:0]  ext_count,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_valid,
    input  logic [15:0]       fetch_data,
    output logic [2:0]        cp_sel,
    output logic              cp_reg,
    output logic              cp_wr,
    output logic              cp_rd,
    output logic [15:0]       cp_wdata,
    input  logic [15:0]       cp_rdata,
    output logic              cp_svc,
    output logic              busy,
    output logic              done,
    output logic              taken,
    output logic [ADDR_W-1:0] target,
    output logic              illegal,
    output logic              proto_err
);
    localparam int CNT_W = $clog2(POLL_LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST_POLL = CNT_W'(POLL_LIMIT - 1);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);

    typedef struct packed {
        cpb_state_e        st;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] base;
        logic [EXT_W-1:0]  ext_left;
        logic [2:0]        cpid;
        logic              is_long;
        logic [5:0]        sel;
        logic [15:0]       disp_hi;
        logic [CNT_W-1:0]  polls;
        logic              svc;
        logic              result;
        logic              taken;
        logic [ADDR_W-1:0] target;
        logic              illegal;
        logic              perr;
    } seq_t;

    seq_t q, d;

    logic        dec_legal;
    logic        dec_long;
    logic [2:0]  dec_cpid;
    logic [5:0]  dec_sel;
    cpb_resp_e   rsp_kind;
    logic        rsp_bit;
    logic [ADDR_W-1:0] tgt_sum;

    cpb_opdec u_opdec (
        .op_word  (fetch_data),
        .legal    (dec_legal),
        .is_long  (dec_long),
        .cpid     (dec_cpid),
        .cond_sel (dec_sel)
    );

    cpb_resp_class u_rsp (
        .rsp_word (cp_rdata),
        .rsp_kind (rsp_kind),
        .cond_bit (rsp_bit)
    );

    cpb_target #(.ADDR_W(ADDR_W)) u_tgt (
        .base_addr (q.base),
        .is_long   (q.is_long),
        .hi_word   (q.disp_hi),
        .lo_word   (fetch_data),
        .tgt_addr  (tgt_sum)
    );

    always_comb begin
        d         = q;
        d.svc     = 1'b0;
        fetch_req = 1'b0;
        cp_wr     = 1'b0;
        cp_rd     = 1'b0;

        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.pc       = instr_addr;
                    d.ext_left = ext_count;
                    d.taken    = 1'b0;
                    d.target   = '0;
                    d.illegal  = 1'b0;
                    d.perr     = 1'b0;
                    d.st       = S_DECODE;
                end
            end
            S_DECODE: begin
                fetch_req = 1'b1;
                if (fetch_valid) begin
                    d.pc = q.pc + WORD_STEP;
                    if (!dec_legal) begin
                        d.illegal = 1'b1;
                        d.st      = S_DONE;
                    end else begin
                        d.cpid    = dec_cpid;
                        d.is_long = dec_long;
                        d.sel     = dec_sel;
                        d.base    = q.pc + WORD_STEP;
                        d.st      = S_WRITE_COND;
                    end
                end
            end
            S_WRITE_COND: begin
                cp_wr   = 1'b1;
                d.polls = '0;
                d.st    = S_POLL;
            end
            S_POLL: begin
                if (!q.svc) begin
                    cp_rd   = 1'b1;
                    d.polls = q.polls + 1'b1;
                    if (rsp_kind == RSP_NULL) begin
                        d.result = rsp_bit;
                        d.st     = (q.ext_left != '0) ? S_SKIP_EXT : S_FETCH_DISP_HI;
                    end else if (q.polls == LAST_POLL) begin
                        d.perr = 1'b1;
                        d.st   = S_DONE;
                    end else if (rsp_kind == RSP_SERVICE) begin
                        d.svc = 1'b1;
                    end
                end
            end
            S_SKIP_EXT: begin
                fetch_req = 1'b1;
                if (fetch_valid) begin
                    d.pc       = q.pc + WORD_STEP;
                    d.ext_left = q.ext_left - 1'b1;
                    if (q.ext_left == EXT_W'(1)) begin
                        d.st = S_FETCH_DISP_HI;
                    end
                end
            end
            S_FETCH_DISP_HI: begin
                fetch_req = 1'b1;
                if (fetch_valid) begin
                    d.pc = q.pc + WORD_STEP;
                    if (q.is_long) begin
                        d.disp_hi = fetch_data;
                        d.st      = S_FETCH_DISP_LO;
                    end else begin
                        d.target = tgt_sum;
                        d.taken  = q.result;
                        d.st     = S_DONE;
                    end
                end
            end
            S_FETCH_DISP_LO: begin
                fetch_req = 1'b1;
                if (fetch_valid) begin
                    d.pc     = q.pc + WORD_STEP;
                    d.target = tgt_sum;
                    d.taken  = q.result;
                    d.st     = S_DONE;
                end
            end
            S_DONE: begin
                d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        fetch_addr = q.pc;
        cp_sel     = q.cpid;
        cp_reg     = (q.st == S_WRITE_COND) ? CP_REG_CND : CP_REG_RSP;
        cp_wdata   = {10'b0, q.sel};
        cp_svc     = q.svc;
        busy       = (q.st != S_IDLE);
        done       = (q.st == S_DONE);
        taken      = q.taken;
        target     = q.target;
        illegal    = q.illegal;
        proto_err  = q.perr;
    end
endmodule

// File: rtl/cpb_branch_seq_chk.sv
module cpb_branch_seq_chk #(
    parameter int POLL_LIMIT = 256
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        taken,
    input logic        illegal,
    input logic        proto_err,
    input logic        cp_wr,
    input logic        cp_rd,
    input logic        cp_svc,
    input logic        cp_reg,
    input logic [2:0]  cp_sel,
    input logic [15:0] cp_wdata
);
    int   poll_cnt;
    logic cp_used;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_cnt <= 0;
            cp_used  <= 1'b0;
        end else begin
            if (cp_wr) poll_cnt <= 0;
            else if (cp_rd) poll_cnt <= poll_cnt + 1;
            if (start && !busy) cp_used <= 1'b0;
            else if (cp_wr || cp_rd) cp_used <= 1'b1;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_WR_THEN_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        cp_wr |=> (cp_rd && !cp_wr)); // R4
    AST_WDATA_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        cp_wr |-> (cp_wdata[15:6] == 10'd0 && cp_reg == 1'b0)); // R4
    AST_READ_REG: assert property (@(posedge clk) disable iff (!rst_n)
        cp_rd |-> cp_reg); // R4
    AST_SVC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        cp_svc |-> (!cp_rd && $past(cp_rd))); // R6
    AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_rd && $past(cp_rd || cp_wr || cp_svc)) |-> $stable(cp_sel)); // R3
    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt <= POLL_LIMIT); // R10
    AST_PERR_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && proto_err) |-> (poll_cnt == POLL_LIMIT)); // R10
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> !cp_used); // R2
    AST_TAKEN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(taken && (illegal || proto_err))); // R11
endmodule

bind cpb_branch_seq cpb_branch_seq_chk #(.POLL_LIMIT(POLL_LIMIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .taken     (taken),
    .illegal   (illegal),
    .proto_err (proto_err),
    .cp_wr     (cp_wr),
    .cp_rd     (cp_rd),
    .cp_svc    (cp_svc),
    .cp_reg    (cp_reg),
    .cp_sel    (cp_sel),
    .cp_wdata  (cp_wdata)
);

// File: tb/sim_cpb_branch_seq.sv
module sim_cpb_branch_seq;
    localparam int ADDR_W = 32;
    localparam int LIMIT  = 256;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] instr_addr = '0;
    logic [1:0]        ext_count = '0;
    logic              fetch_req;
    logic [ADDR_W-1:0] fetch_addr;
    logic              fetch_valid;
    logic [15:0]       fetch_data;
    logic [2:0]        cp_sel;
    logic              cp_reg;
    logic              cp_wr;
    logic              cp_rd;
    logic [15:0]       cp_wdata;
    logic [15:0]       cp_rdata;
    logic              cp_svc;
    logic              busy;
    logic              done;
    logic              taken;
    logic [ADDR_W-1:0] target;
    logic              illegal;
    logic              proto_err;

    always #5 clk = ~clk;

    cpb_branch_seq #(.ADDR_W(ADDR_W), .POLL_LIMIT(LIMIT), .EXT_W(2)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .instr_addr(instr_addr),
        .ext_count(ext_count), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_valid(fetch_valid), .fetch_data(fetch_data), .cp_sel(cp_sel),
        .cp_reg(cp_reg), .cp_wr(cp_wr), .cp_rd(cp_rd), .cp_wdata(cp_wdata),
        .cp_rdata(cp_rdata), .cp_svc(cp_svc), .busy(busy), .done(done),
        .taken(taken), .target(target), .illegal(illegal), .proto_err(proto_err)
    );

    // instruction memory and coprocessor model
    logic [15:0]       imem [0:7];
    logic [ADDR_W-1:0] base = '0;
    logic              stall = 1'b0;
    logic [15:0]       rsp [0:511];
    int                rsp_len = 0;
    int                rd_idx, wr_cnt, svc_cnt, f_cnt, addr_bad, sel_bad;
    logic [15:0]       wr_data;
    logic [2:0]        wr_sel;
    logic              wr_reg;
    logic [2:0]        exp_sel = '0;
    logic              clr = 1'b0;

    assign fetch_valid = fetch_req && !stall;
    assign fetch_data  = imem[3'((fetch_addr - base) >> 1)];
    assign cp_rdata    = (rd_idx < rsp_len) ? rsp[rd_idx[8:0]] : 16'h8000;

    always @(posedge clk) begin
        if (clr) begin
            rd_idx <= 0; wr_cnt <= 0; svc_cnt <= 0; f_cnt <= 0;
            addr_bad <= 0; sel_bad <= 0;
        end else begin
            if (cp_rd) begin
                rd_idx <= rd_idx + 1;
                if (cp_sel != exp_sel || cp_reg != 1'b1) sel_bad <= sel_bad + 1;
            end
            if (cp_wr) begin
                wr_cnt <= wr_cnt + 1; wr_data <= cp_wdata;
                wr_sel <= cp_sel; wr_reg <= cp_reg;
            end
            if (cp_svc) svc_cnt <= svc_cnt + 1;
            if (fetch_req && fetch_valid) begin
                f_cnt <= f_cnt + 1;
                if (fetch_addr != base + ADDR_W'(2 * f_cnt)) addr_bad <= addr_bad + 1;
            end
        end
    end

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // directed/random case
    task automatic run_case(input logic [15:0] op, input logic [1:0] ext,
                            input logic [15:0] dhi, input logic [15:0] dlo,
                            input int n_pre, input logic res, input bit tmo,
                            input bit poke, input int stall_pct);
        bit legal, lng;
        int exp_svc, exp_rd, exp_f, guard;
        logic [31:0] exp_tgt, d32;
        legal = (op[15:12] == 4'hF) && (op[8:6] == 3'b010 || op[8:6] == 3'b011);
        lng   = (op[8:6] == 3'b011);
        base  = {$urandom(), 1'b0} & 32'h7FFF_FFFE;
        exp_sel = op[11:9];
        imem[0] = op;
        for (int i = 1; i < 8; i++) imem[i] = 16'($urandom());
        imem[1 + ext] = lng ? dhi : dlo;
        if (lng) imem[2 + ext] = dlo;
        exp_svc = 0;
        for (int i = 0; i < n_pre; i++) begin
            if ($urandom_range(0, 1) == 1) begin
                rsp[i] = {1'b0, 2'($urandom_range(1, 3)), 13'($urandom())};
                exp_svc++;
            end else begin
                rsp[i] = 16'h8000 | 16'($urandom());
            end
        end
        rsp[n_pre] = {3'b000, 12'($urandom()), res};
        rsp_len = tmo ? 0 : n_pre + 1;
        if (tmo) exp_svc = 0;
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        start = 1'b1; instr_addr = base; ext_count = ext;
        @(negedge clk); start = 1'b0;
        instr_addr = base + 32'd100; ext_count = ~ext;
        stall = ($urandom_range(0, 99) < stall_pct);
        @(negedge clk);
        if (poke) start = 1'b1;
        guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk); start = 1'b0;
            stall = ($urandom_range(0, 99) < stall_pct);
            guard++;
        end
        stall = 1'b0;
        start = 1'b0;
        check("R11 done reached", {31'd0, done}, 32'd1);
        if (!legal) begin
            check("R2 illegal flag", {31'd0, illegal}, 32'd1);
            check("R2 no cp write", 32'(wr_cnt), 32'd0);
            check("R2 no cp read", 32'(rd_idx), 32'd0);
            check("R2 taken low", {31'd0, taken}, 32'd0);
            check("R2 target zero", target, 32'd0);
        end else if (tmo) begin
            check("R10 proto_err", {31'd0, proto_err}, 32'd1);
            check("R10 read count", 32'(rd_idx), 32'(LIMIT));
            check("R10 taken low", {31'd0, taken}, 32'd0);
            check("R10 target zero", target, 32'd0);
            check("R10 no disp fetch", 32'(f_cnt), 32'd1);
        end else begin
            d32 = lng ? {dhi, dlo} : {{16{dlo[15]}}, dlo};
            exp_tgt = base + 32'd2 + d32;
            exp_rd = n_pre + 1;
            exp_f  = 1 + ext + (lng ? 2 : 1);
            check(lng ? "R9 long target" : "R8 word target", target, exp_tgt);
            check("R5 taken=result", {31'd0, taken}, {31'd0, res});
            check("R5 read count", 32'(rd_idx), 32'(exp_rd));
            check("R6 svc pulses", 32'(svc_cnt), 32'(exp_svc));
            check("R7 fetch count", 32'(f_cnt), 32'(exp_f));
            check("R12 fetch addresses", 32'(addr_bad), 32'd0);
            check("R4 one write", 32'(wr_cnt), 32'd1);
            check("R4 write data", {16'd0, wr_data}, {26'd0, op[5:0]});
            check("R4 write reg", {31'd0, wr_reg}, 32'd0);
            check("R3 write sel", {29'd0, wr_sel}, {29'd0, op[11:9]});
            check("R3 read sel/reg", 32'(sel_bad), 32'd0);
            check("R11 flags clear", {30'd0, illegal, proto_err}, 32'd0);
            if (poke) check("R1 start ignored target", target, exp_tgt);
        end
        @(negedge clk);
        check("R11 done one cycle", {31'd0, done}, 32'd0);
        if (legal && !tmo) check("R11 target held", target, base + 32'd2 +
                              (lng ? {dhi, dlo} : {{16{dlo[15]}}, dlo}));
    endtask

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (finished) disable watchdog;
        end
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R1 reset busy", {31'd0, busy}, 32'd0);
        check("R1 reset done", {31'd0, done}, 32'd0);
        check("R1 reset strobes", {28'd0, fetch_req, cp_wr, cp_rd, cp_svc}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {30'd0, busy, done}, 32'd0);

        // directed corner cases
        run_case(16'hF4A5, 2'd0, 16'h0, 16'h0040, 0, 1'b1, 1'b0, 1'b0, 0);   // R8 positive
        run_case(16'hF2BF, 2'd1, 16'h0, 16'h8000, 2, 1'b0, 1'b0, 1'b0, 0);   // R8 negative
        run_case(16'hFEC1, 2'd3, 16'hFFFF, 16'hFFF0, 3, 1'b1, 1'b0, 1'b0, 30); // R9 R7
        run_case(16'hE4A5, 2'd0, 16'h0, 16'h0010, 0, 1'b1, 1'b0, 1'b0, 0);   // R2 nibble
        run_case(16'hF405, 2'd0, 16'h0, 16'h0010, 0, 1'b1, 1'b0, 1'b0, 0);   // R2 fmt 000
        run_case(16'hF7C5, 2'd2, 16'h0, 16'h0010, 0, 1'b1, 1'b0, 1'b0, 0);   // R2 fmt 111
        run_case(16'hF6A9, 2'd2, 16'h0, 16'h0010, 0, 1'b1, 1'b1, 1'b0, 0);   // R10 timeout
        run_case(16'hF0E3, 2'd0, 16'h1234, 16'h5678, LIMIT-1, 1'b1, 1'b0, 1'b0, 0); // R10 edge
        run_case(16'hF8BA, 2'd1, 16'h0, 16'h7FFE, 10, 1'b1, 1'b0, 1'b1, 20); // R1 poke
        // constrained random
        for (int n = 0; n < 40; n++) begin
            logic [15:0] op;
            op = {4'hF, 3'($urandom()), 1'b0, 1'b1, 1'($urandom()), 6'($urandom())};
            if ($urandom_range(0, 9) == 0) op[8:6] = 3'($urandom());
            run_case(op, 2'($urandom()), 16'($urandom()), 16'($urandom()),
                     $urandom_range(0, 12), 1'($urandom()), 1'b0,
                     ($urandom_range(0, 3) == 0), $urandom_range(0, 50));
        end
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule